// File: doc/BRIEF.md
# Energy Efficient Ethernet Transmit LPI Sequencer

This block decides when an Ethernet transmitter may send low-power idle (LPI) and when it must leave it. Software programs two timers and a control word. The control word holds an enable, an automatic mode and the PHY link status. The sequencer moves through four states: ACTIVE, WAIT_LINK, LPI and WAKE. It enters LPI only after the link has been reported good without a break for the programmed number of millisecond ticks. After LPI ends, it holds the transmitter back for the programmed number of microsecond ticks.

The block also watches a receive-side LPI indication. It records four events in sticky flags: transmit entry, transmit exit, receive entry and receive exit. An interrupt output stays high while any flag is set. Reading the control word returns the flags and clears them. Timing comes from two external single-cycle tick inputs, one for microseconds and one for milliseconds, so the block runs from any system clock.

The register port is a simple strobe interface. `reg_sel` = 0 selects the control word and `reg_sel` = 1 selects the timer word. Writes take effect at the clock edge where `reg_wr` is high. Read data appears on `reg_rdata` one cycle after the `reg_rd` strobe and holds until the next read.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset, `tx_lpi`, `tx_hold` and `lpi_irq` are low, the control word reads 0, and the timer word reads the reset parameter values (link-stable 1000, wake 30).
- R2: The timer word carries the wake count in bits 15:0 and the link-stable count in bits 26:16. Bits 31:27 are ignored on write and read as zero.
- R3: LPI (`tx_lpi` high) is never entered before the link-stable counter has seen at least LS `tick_ms` pulses since the link status bit was last set.
- R4: When the link status bit is clear, the state returns to ACTIVE on the next clock from any state, `tx_lpi` and `tx_hold` drop, and the link-stable count restarts from zero.
- R5: After LPI ends for any reason other than link loss, `tx_hold` stays high in WAKE until TW `tick_us` pulses have been counted, then falls.
- R6: Clearing the enable bit while in LPI forces the exit from LPI on the next clock.
- R7: With automatic mode set, entry needs `tx_idle` high, and a low `tx_idle` in LPI starts the wake. With automatic mode clear, `tx_idle` has no effect on entering or staying in LPI.
- R8: Control word bits 7:4 are sticky flags: bit 4 transmit LPI entry, bit 5 transmit LPI exit, bit 6 rise of `rx_lpi`, bit 7 fall of `rx_lpi`. Each sets at the edge where its event occurs.
- R9: A control-word read returns the flags as they were before the read and clears them. `lpi_irq` is the OR of the flags. A flag whose event occurs in the same cycle as the read stays set.
- R10: Control word layout: bit 0 enable, bit 1 automatic mode, bit 2 link status (all three read/write), bit 8 reads 1 while in LPI, bit 9 reads the registered `rx_lpi` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the timer word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd` |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| tx_idle | input | 1 | High when no transmit data is pending |
| rx_lpi | input | 1 | Receive path is in LPI |
| tx_lpi | output | 1 | Transmitter should signal LPI |
| tx_hold | output | 1 | Normal transmission blocked (LPI or wake) |
| lpi_irq | output | 1 | High while any event flag is set |

## Verification
A wrong sequencer state shows on `tx_lpi` or `tx_hold` one clock after the edge where the decision was taken. A miscounted timer shows as an entry or release that comes one or more tick pulses early or late. A lost or stale event flag first shows on `lpi_irq` in the cycle after the event. It also shows in the next control-word read, including the case where a read and an event land in the same cycle. The bench therefore compares all three outputs on every clock and compares every read against its own model.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE    = 2'd0,
    ST_WAIT_LINK = 2'd1,
    ST_LPI       = 2'd2,
    ST_WAKE      = 2'd3
  } lpi_state_e;

  // control word bit positions
  localparam int CB_EN    = 0;
  localparam int CB_AUTO  = 1;
  localparam int CB_LINK  = 2;
  localparam int CB_FLAG0 = 4;
  localparam int CB_TXLPI = 8;
  localparam int CB_RXLPI = 9;

  // flag vector order
  localparam int FL_TX_ENTRY = 0;
  localparam int FL_TX_EXIT  = 1;
  localparam int FL_RX_ENTRY = 2;
  localparam int FL_RX_EXIT  = 3;
  localparam int NUM_FLAGS   = 4;

  // timer word: wake count at bit 0, link-stable count at bit 16
  localparam int TW_LSB = 0;
  localparam int LS_LSB = 16;

  function automatic logic limit_reached(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction

  function automatic logic auto_blocked(input logic auto_en, input logic tx_idle);
    return auto_en && !tx_idle;
  endfunction

endpackage

// File: rtl/eee_lpi_tick_cnt.sv
module eee_lpi_tick_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         done
);
  import eee_lpi_pkg::*;

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (clr)                     cnt <= '0;
    else if (inc && cnt != CNT_MAX)   cnt <= cnt + 1'b1;
  end

  assign done = limit_reached(32'(cnt), 32'(limit));

  // R4: a clear always restarts the count
  a_r4_restart_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);

  // R5: the counter saturates instead of wrapping
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

endmodule

// File: rtl/eee_lpi_regs.sv
module eee_lpi_regs #(
  parameter int DW     = 32,
  parameter int LS_W   = 11,
  parameter int TW_W   = 16,
  parameter int RST_LS = 1000,
  parameter int RST_TW = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            rd,
  input  logic            sel,
  input  logic [DW-1:0]   wdata,
  input  logic [3:0]      flags,
  input  logic            tx_in_lpi,
  input  logic            rx_lvl,
  output logic            lpi_en,
  output logic            auto_en,
  output logic            link_ok,
  output logic [LS_W-1:0] ls_val,
  output logic [TW_W-1:0] tw_val,
  output logic            rd_ctrl,
  output logic [DW-1:0]   rdata
);
  import eee_lpi_pkg::*;

  logic [DW-1:0] ctrl_view;
  logic [DW-1:0] timer_view;
  logic          unused_wbits;

  assign rd_ctrl      = rd && !sel;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpi_en  <= 1'b0;
      auto_en <= 1'b0;
      link_ok <= 1'b0;
      ls_val  <= LS_W'(RST_LS);
      tw_val  <= TW_W'(RST_TW);
    end else if (wr) begin
      if (!sel) begin
        lpi_en  <= wdata[CB_EN];
        auto_en <= wdata[CB_AUTO];
        link_ok <= wdata[CB_LINK];
      end else begin
        tw_val <= wdata[TW_LSB +: TW_W];
        ls_val <= wdata[LS_LSB +: LS_W];
      end
    end
  end

  always_comb begin
    ctrl_view                        = '0;
    ctrl_view[CB_EN]                 = lpi_en;
    ctrl_view[CB_AUTO]               = auto_en;
    ctrl_view[CB_LINK]               = link_ok;
    ctrl_view[CB_FLAG0 +: NUM_FLAGS] = flags;
    ctrl_view[CB_TXLPI]              = tx_in_lpi;
    ctrl_view[CB_RXLPI]              = rx_lvl;
    timer_view                       = '0;
    timer_view[TW_LSB +: TW_W]       = tw_val;
    timer_view[LS_LSB +: LS_W]       = ls_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= sel ? timer_view : ctrl_view;
  end

  // R2: a timer write lands in both fields
  a_r2_timer_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel) |=> (tw_val == $past(wdata[TW_LSB +: TW_W]) &&
                     ls_val == $past(wdata[LS_LSB +: LS_W])));

endmodule

// File: rtl/eee_lpi_events.sv
module eee_lpi_events (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_entry,
  input  logic       tx_exit,
  input  logic       rx_lpi_in,
  input  logic       rd_clr,
  output logic [3:0] flags,
  output logic       rx_lvl,
  output logic       irq
);
  import eee_lpi_pkg::*;

  logic       rx_entry;
  logic       rx_exit;
  logic [3:0] ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_lvl <= 1'b0;
    else        rx_lvl <= rx_lpi_in;
  end

  assign rx_entry = rx_lpi_in && !rx_lvl;
  assign rx_exit  = !rx_lpi_in && rx_lvl;

  always_comb begin
    ev              = '0;
    ev[FL_TX_ENTRY] = tx_entry;
    ev[FL_TX_EXIT]  = tx_exit;
    ev[FL_RX_ENTRY] = rx_entry;
    ev[FL_RX_EXIT]  = rx_exit;
  end

  // set wins over clear-on-read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~{NUM_FLAGS{rd_clr}}) | ev;
  end

  assign irq = |flags;

  // R9: an event in a read cycle survives the clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((flags & $past(ev)) == $past(ev)));

  // R9: a read with no events empties the flags and drops irq
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ev == '0) |=> (flags == '0 && !irq));

  // R8: transmit entry sets its flag
  a_r8_tx_entry_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tx_entry |=> flags[FL_TX_ENTRY]);

endmodule

// File: rtl/eee_lpi_fsm.sv
module eee_lpi_fsm (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lpi_en,
  input  logic                    auto_en,
  input  logic                    link_ok,
  input  logic                    tx_idle,
  input  logic                    ls_done,
  input  logic                    tw_done,
  output eee_lpi_pkg::lpi_state_e state,
  output logic                    ev_tx_entry,
  output logic                    ev_tx_exit
);
  import eee_lpi_pkg::*;

  lpi_state_e nxt;
  logic       busy;

  assign busy = auto_blocked(auto_en, tx_idle);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_ACTIVE:    if (lpi_en && link_ok && !busy) nxt = ST_WAIT_LINK;
      ST_WAIT_LINK: begin
        if (!link_ok || !lpi_en || busy) nxt = ST_ACTIVE;
        else if (ls_done)                nxt = ST_LPI;
      end
      ST_LPI: begin
        if (!link_ok)             nxt = ST_ACTIVE;
        else if (!lpi_en || busy) nxt = ST_WAKE;
      end
      ST_WAKE:      if (!link_ok || tw_done) nxt = ST_ACTIVE;
      default:      nxt = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ACTIVE;
    else        state <= nxt;
  end

  assign ev_tx_entry = (state != ST_LPI) && (nxt == ST_LPI);
  assign ev_tx_exit  = (state == ST_LPI) && (nxt != ST_LPI);

  // R4: link loss returns to ACTIVE from anywhere
  a_r4_link_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |=> state == ST_ACTIVE);

  // R3: no entry before the link-stable time has elapsed
  a_r3_entry_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_LINK && !ls_done) |=> state != ST_LPI);

  // R5: wake is held until the wake count is reached
  a_r5_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE && link_ok && !tw_done) |=> state == ST_WAKE);

  // R6: disabling forces the exit
  a_r6_disable_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LPI && !lpi_en) |=> state != ST_LPI);

  // R7: pending data in automatic mode blocks entry
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !tx_idle && state != ST_LPI) |=> state != ST_LPI);

endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl #(
  parameter int DATA_W = 32,
  parameter int LS_W   = 11,
  parameter int TW_W   = 16,
  parameter int RST_LS = 1000,
  parameter int RST_TW = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_us,
  input  logic              tick_ms,
  input  logic              tx_idle,
  input  logic              rx_lpi,
  output logic              tx_lpi,
  output logic              tx_hold,
  output logic              lpi_irq
);
  import eee_lpi_pkg::*;

  logic            lpi_en, auto_en, link_ok, rd_ctrl;
  logic [LS_W-1:0] ls_val, ls_cnt;
  logic [TW_W-1:0] tw_val, tw_cnt;
  logic            ls_done, tw_done;
  logic            ev_tx_entry, ev_tx_exit;
  logic [3:0]      flags;
  logic            rx_lvl;
  lpi_state_e      state;
  logic            in_lpi, in_wake;

  assign in_lpi  = (state == ST_LPI);
  assign in_wake = (state == ST_WAKE);

  eee_lpi_regs #(
    .DW(DATA_W), .LS_W(LS_W), .TW_W(TW_W), .RST_LS(RST_LS), .RST_TW(RST_TW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .sel(reg_sel),
    .wdata(reg_wdata), .flags(flags), .tx_in_lpi(in_lpi), .rx_lvl(rx_lvl),
    .lpi_en(lpi_en), .auto_en(auto_en), .link_ok(link_ok),
    .ls_val(ls_val), .tw_val(tw_val), .rd_ctrl(rd_ctrl), .rdata(reg_rdata)
  );

  eee_lpi_tick_cnt #(.W(LS_W)) u_ls_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!link_ok), .inc(tick_ms),
    .limit(ls_val), .cnt(ls_cnt), .done(ls_done)
  );

  eee_lpi_tick_cnt #(.W(TW_W)) u_tw_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!in_wake), .inc(tick_us),
    .limit(tw_val), .cnt(tw_cnt), .done(tw_done)
  );

  eee_lpi_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .lpi_en(lpi_en), .auto_en(auto_en),
    .link_ok(link_ok), .tx_idle(tx_idle), .ls_done(ls_done), .tw_done(tw_done),
    .state(state), .ev_tx_entry(ev_tx_entry), .ev_tx_exit(ev_tx_exit)
  );

  eee_lpi_events u_events (
    .clk(clk), .rst_n(rst_n), .tx_entry(ev_tx_entry), .tx_exit(ev_tx_exit),
    .rx_lpi_in(rx_lpi), .rd_clr(rd_ctrl), .flags(flags), .rx_lvl(rx_lvl),
    .irq(lpi_irq)
  );

  assign tx_lpi  = in_lpi;
  assign tx_hold = in_lpi || in_wake;

  // R4: with the link down the link-stable count stays at zero
  a_r4_ls_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |=> (ls_cnt == '0 || link_ok));

  // R5: the wake counter only runs in WAKE
  a_r5_tw_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_wake |=> tw_cnt == '0);

endmodule

// File: tb/eee_lpi_ctrl_bench.sv
`timescale 1ns/1ps
module eee_lpi_ctrl_bench;
  localparam int RST_LS = 1000;
  localparam int RST_TW = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_us = 1'b0, tick_ms = 1'b0, tx_idle = 1'b0, rx_lpi = 1'b0;
  logic        tx_lpi, tx_hold, lpi_irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  eee_lpi_ctrl #(.RST_LS(RST_LS), .RST_TW(RST_TW)) u_eee_lpi_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_us(tick_us), .tick_ms(tick_ms),
    .tx_idle(tx_idle), .rx_lpi(rx_lpi), .tx_lpi(tx_lpi), .tx_hold(tx_hold),
    .lpi_irq(lpi_irq)
  );

  // ---------------- behavioural reference model ----------------
  // phases: 0 running, 1 waiting for link time, 2 low-power idle, 3 waking
  int          m_phase;
  bit          m_en, m_auto, m_link, m_rxprev;
  int          m_ls, m_tw, m_ms_seen, m_us_seen;
  bit [3:0]    m_fl;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_en = 0; m_auto = 0; m_link = 0; m_rxprev = 0;
      m_ls = RST_LS; m_tw = RST_TW; m_ms_seen = 0; m_us_seen = 0;
      m_fl = '0; m_rdata = '0;
    end else begin
      int  nphase;
      bit  hold_off;
      bit [3:0] evs;
      hold_off = m_auto && (tx_idle == 1'b0);
      nphase = m_phase;
      if (m_phase == 0) begin
        if (m_en && m_link && !hold_off) nphase = 1;
      end else if (m_phase == 1) begin
        if (!m_link || !m_en || hold_off) nphase = 0;
        else if (m_ms_seen >= m_ls) nphase = 2;
      end else if (m_phase == 2) begin
        if (!m_link) nphase = 0;
        else if (!m_en || hold_off) nphase = 3;
      end else begin
        if (!m_link || m_us_seen >= m_tw) nphase = 0;
      end
      evs[0] = (m_phase != 2) && (nphase == 2);
      evs[1] = (m_phase == 2) && (nphase != 2);
      evs[2] = rx_lpi && !m_rxprev;
      evs[3] = !rx_lpi && m_rxprev;
      if (reg_rd) begin
        if (reg_sel) m_rdata = (32'(m_ls) << 16) | 32'(m_tw);
        else m_rdata = 32'(m_en) | (32'(m_auto) << 1) | (32'(m_link) << 2) |
                       (32'(m_fl) << 4) | (32'(m_phase == 2) << 8) | (32'(m_rxprev) << 9);
      end
      if (reg_rd && !reg_sel) m_fl = '0;
      m_fl = m_fl | evs;
      if (!m_link) m_ms_seen = 0;
      else if (tick_ms && m_ms_seen < 2047) m_ms_seen++;
      if (m_phase != 3) m_us_seen = 0;
      else if (tick_us && m_us_seen < 65535) m_us_seen++;
      if (reg_wr) begin
        if (!reg_sel) begin
          m_en = reg_wdata[0]; m_auto = reg_wdata[1]; m_link = reg_wdata[2];
        end else begin
          m_tw = int'(reg_wdata[15:0]); m_ls = int'(reg_wdata[26:16]);
        end
      end
      m_phase = nphase;
      m_rxprev = rx_lpi;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 tx_lpi vs model", 32'(tx_lpi), 32'(m_phase == 2));
      chk("R5 tx_hold vs model", 32'(tx_hold), 32'(m_phase >= 2));
      chk("R9 lpi_irq vs model", 32'(lpi_irq), 32'(m_fl != 0));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, input string tag, output logic [31:0] v);
    reg_rd = 1'b1; reg_sel = sel;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
    chk(tag, v, m_rdata);
  endtask

  task automatic pulse_ms(input int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1; @(negedge clk); tick_ms = 1'b0; @(negedge clk);
    end
  endtask

  task automatic pulse_us(input int n);
    for (int i = 0; i < n; i++) begin
      tick_us = 1'b1; @(negedge clk); tick_us = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] v;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 tx_lpi after reset", 32'(tx_lpi), 0);
    chk("R1 tx_hold after reset", 32'(tx_hold), 0);
    chk("R1 irq after reset", 32'(lpi_irq), 0);
    rd_reg(1'b0, "R1 control read", v);
    chk("R1 control reset value", v, 32'h0);
    rd_reg(1'b1, "R1 timer read", v);
    chk("R1 timer reset value", v, 32'h03E8_001E);

    // R2 timer layout
    wr_reg(1'b1, 32'hFFFF_FFFF);
    rd_reg(1'b1, "R2 timer read", v);
    chk("R2 upper bits ignored", v, 32'h07FF_FFFF);
    wr_reg(1'b1, 32'h0003_0004);
    rd_reg(1'b1, "R2 timer read", v);
    chk("R2 LS=3 TW=4 packed", v, 32'h0003_0004);

    // R3 / R7 non-automatic entry, tx busy ignored
    tx_idle = 1'b0;
    wr_reg(1'b0, 32'h5);
    step(3);
    pulse_ms(2);
    chk("R3 no LPI before LS ticks", 32'(tx_lpi), 0);
    pulse_ms(1);
    step(2);
    chk("R3 LPI after LS ticks", 32'(tx_lpi), 1);
    chk("R7 busy ignored without auto", 32'(tx_hold), 1);
    chk("R8 irq on entry", 32'(lpi_irq), 1);
    rd_reg(1'b0, "R10 control read", v);
    chk("R10 R8 control layout with entry flag", v, 32'h0000_0115);
    chk("R9 irq dropped by read", 32'(lpi_irq), 0);

    // R6 / R5 disable forces exit, wake timing
    wr_reg(1'b0, 32'h4);
    step(1);
    chk("R6 LPI left after disable", 32'(tx_lpi), 0);
    chk("R5 hold during wake", 32'(tx_hold), 1);
    pulse_us(3);
    chk("R5 hold before TW ticks", 32'(tx_hold), 1);
    pulse_us(1);
    step(2);
    chk("R5 hold released after TW ticks", 32'(tx_hold), 0);
    rd_reg(1'b0, "R8 control read", v);
    chk("R8 exit flag", v, 32'h0000_0024);

    // R4 link drop
    wr_reg(1'b0, 32'h5);
    step(4);
    chk("R4 re-entry with stable link", 32'(tx_lpi), 1);
    wr_reg(1'b0, 32'h1);
    step(1);
    chk("R4 link drop leaves LPI", 32'(tx_lpi), 0);
    chk("R4 link drop skips wake", 32'(tx_hold), 0);
    wr_reg(1'b0, 32'h5);
    step(2);
    pulse_ms(2);
    chk("R4 count restarted", 32'(tx_lpi), 0);
    pulse_ms(1);
    step(2);
    chk("R4 entry after full LS again", 32'(tx_lpi), 1);

    // R7 automatic mode
    tx_idle = 1'b1;
    wr_reg(1'b0, 32'h7);
    rd_reg(1'b0, "R9 control read", v);
    step(2);
    chk("R7 idle keeps LPI in auto", 32'(tx_lpi), 1);
    tx_idle = 1'b0;
    step(2);
    chk("R7 pending data wakes", 32'(tx_lpi), 0);
    chk("R7 wake holds", 32'(tx_hold), 1);
    pulse_us(4);
    step(3);
    chk("R7 wake complete", 32'(tx_hold), 0);
    step(5);
    chk("R7 busy blocks entry", 32'(tx_lpi), 0);
    tx_idle = 1'b1;
    step(3);
    chk("R7 idle re-enters", 32'(tx_lpi), 1);

    // R8 receive events
    rd_reg(1'b0, "R9 control read", v);
    rx_lpi = 1'b1;
    step(3);
    rd_reg(1'b0, "R8 control read", v);
    chk("R8 rx entry flag", 32'(v[6]), 1);
    chk("R10 rx level bit", 32'(v[9]), 1);
    rx_lpi = 1'b0;
    step(3);
    rd_reg(1'b0, "R8 control read", v);
    chk("R8 rx exit flag only", 32'(v[7:6]), 32'h2);

    // R9 set wins over clear
    reg_rd = 1'b1; reg_sel = 1'b0; rx_lpi = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R9 read returns pre-event flags", 32'(reg_rdata[7:4]), 0);
    chk("R9 irq kept by same-cycle event", 32'(lpi_irq), 1);
    rd_reg(1'b0, "R9 control read", v);
    chk("R9 event flag survived", 32'(v[6]), 1);
    chk("R9 irq cleared", 32'(lpi_irq), 0);

    step(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule